// File: doc/BRIEF.md
# Frequency-Compensated Beep Tone Generator

This block makes the square wave that drives a keyboard beeper. A counter runs from reset at half the system clock rate and is never reloaded. Software picks the tone by writing a one-hot bit into a tone-select register; the chosen counter bit becomes the beep line while the enable bit in a separate control register is set.

The system clock can be slowed to one half or one thirty-second of full speed by a frequency sequencer outside this block. The current frequency code comes in on a port. The block then reads a lower counter bit, so the tone stays the same in absolute terms. When the select field is empty or has several bits set, the output stays low. The output is a register, so enabling, disabling and tap changes never make a short pulse.

Top module: `beep_tone_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `beep_o` is 0; the enable and the select field reset to 0.
- R2: The internal counter starts at 0 and advances by one every second system clock. With the frequency code at full speed, a valid select of field bit k (data bit 10+k) gives a square wave on counter bit 10+k, so a select of data bit 10 gives a period of 4096 system clocks.
- R3: A write to address 1 loads the select field from data bits 18 down to 10; every other data bit of that write is ignored.
- R4: A write to address 0 loads the enable from data bit 0; every other data bit is ignored, and writes to addresses 2 and 3 change nothing.
- R5: Frequency code 2'b01 (half speed) makes the block read a counter bit one position lower than the select names.
- R6: Frequency code 2'b10 (one thirty-second speed) makes the block read a counter bit five positions lower; the position never goes below bit 0.
- R7: Frequency codes 2'b00 and 2'b11 both read the counter bit that the select names.
- R8: If the select field holds no set bit or more than one set bit, `beep_o` is 0.
- R9: `beep_o` is a register. At each rising edge it takes the value of the chosen counter bit as it was before that edge, gated by the enable, select and frequency code as they were before that edge. A write that clears the enable therefore forces the output low from the second rising edge after the write is presented and from then on.
- R10: Register writes never reload or stall the counter; the tone phase after any write matches a counter that has run freely since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Register address: 0 control, 1 tone select |
| wr_data_i | input | DATA_W | Register write data |
| freq_i | input | 2 | Current system clock setting: 00 full, 01 half, 10 one thirty-second, 11 treated as full |
| beep_o | output | 1 | Beep square wave |

## Verification
The checker checks on every cycle that the counter holds or steps by exactly one in step with its prescale phase, and that a write never moves it. It also checks that the output is low during reset, one clock after the enable is clear and one clock after an invalid select. The tone period, the tap shift for each frequency code, the handling of reserved data bits and unused addresses, and the phase across writes depend on long stretches of counter history. Only the bench's cycle-accurate model of a free-running counter can show them, with its explicit period measurement.

// File: rtl/beep_pkg.sv
package beep_pkg;

   typedef enum logic [1:0] {
      FREQ_FULL = 2'b00,
      FREQ_HALF = 2'b01,
      FREQ_SLOW = 2'b10,
      FREQ_RSVD = 2'b11
   } freq_code_e;

endpackage

// File: rtl/beep_prescale_counter.sv
module beep_prescale_counter #(
   parameter int CNT_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             half_o,
   output logic [CNT_W-1:0] cnt_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("beep_prescale_counter: CNT_W must be at least 2");
   end

   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;

   // phase_q divides the system clock by two; the count moves on its high half
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         phase_q <= ~phase_q;
         if (phase_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign half_o = phase_q;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/beep_regs.sv
module beep_regs #(
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 32,
   parameter int SEL_LSB   = 10,
   parameter int SEL_W     = 9,
   parameter int CTRL_ADDR = 0,
   parameter int SEL_ADDR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              en_o,
   output logic [SEL_W-1:0]  sel_o
);

   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   if (SEL_MSB >= DATA_W) begin : g_bad_field
      $error("beep_regs: select field does not fit in the data word");
   end
   if (CTRL_ADDR == SEL_ADDR) begin : g_bad_map
      $error("beep_regs: control and select addresses must differ");
   end
   if (CTRL_ADDR >= (1 << ADDR_W) || SEL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("beep_regs: register address out of range");
   end

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_ADDR);

   logic             en_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == CTRL_A) begin
            en_q <= wr_data_i[0];
         end
         if (wr_addr_i == SEL_A) begin
            sel_q <= wr_data_i[SEL_MSB:SEL_LSB];
         end
      end
   end

   assign en_o  = en_q;
   assign sel_o = sel_q;

endmodule

// File: rtl/beep_tap_select.sv
module beep_tap_select
   import beep_pkg::*;
#(
   parameter int CNT_W      = 19,
   parameter int SEL_LSB    = 10,
   parameter int SEL_W      = 9,
   parameter int HALF_SHIFT = 1,
   parameter int SLOW_SHIFT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             en_i,
   input  logic [1:0]       freq_i,
   output logic             beep_o
);

   localparam int IDX_W   = $clog2(CNT_W);
   localparam int POS_W   = (SEL_W > 1) ? $clog2(SEL_W) : 1;
   localparam int MAX_SH  = (HALF_SHIFT > SLOW_SHIFT) ? HALF_SHIFT : SLOW_SHIFT;
   localparam bit NEEDSAT = (SEL_LSB < MAX_SH);

   if (SEL_LSB + SEL_W > CNT_W) begin : g_bad_cnt
      $error("beep_tap_select: counter too narrow for the select field");
   end
   if (HALF_SHIFT < 0 || SLOW_SHIFT < 0 || MAX_SH >= CNT_W) begin : g_bad_shift
      $error("beep_tap_select: shift amounts out of range");
   end

   // one-hot to binary: each position bit is the OR of the select lines
   // whose index has that bit set
   logic [POS_W-1:0] pos;
   for (genvar b = 0; b < POS_W; b++) begin : g_enc
      logic [SEL_W-1:0] mask;
      for (genvar i = 0; i < SEL_W; i++) begin : g_m
         assign mask[i] = ((i >> b) & 1) != 0;
      end
      assign pos[b] = |(sel_i & mask);
   end

   logic valid;
   assign valid = $onehot(sel_i);

   logic [IDX_W-1:0] idx_raw;
   logic [IDX_W-1:0] shamt;
   logic [IDX_W-1:0] idx;

   assign idx_raw = IDX_W'(SEL_LSB) + IDX_W'(pos);

   always_comb begin
      unique case (freq_code_e'(freq_i))
         FREQ_HALF: shamt = IDX_W'(HALF_SHIFT);
         FREQ_SLOW: shamt = IDX_W'(SLOW_SHIFT);
         default:   shamt = '0;
      endcase
   end

   // a comparator is only built when a shift can reach below bit 0
   if (NEEDSAT) begin : g_sat
      assign idx = (idx_raw < shamt) ? '0 : (idx_raw - shamt);
   end else begin : g_plain
      assign idx = idx_raw - shamt;
   end

   logic beep_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beep_q <= 1'b0;
      end else begin
         beep_q <= en_i & valid & cnt_i[idx];
      end
   end

   assign beep_o = beep_q;

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
   parameter int ADDR_W     = 2,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 19,
   parameter int SEL_LSB    = 10,
   parameter int SEL_W      = 9,
   parameter int CTRL_ADDR  = 0,
   parameter int SEL_ADDR   = 1,
   parameter int HALF_SHIFT = 1,
   parameter int SLOW_SHIFT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        freq_i,
   output logic              beep_o
);

   logic             half_q;
   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic [SEL_W-1:0] sel_q;

   beep_prescale_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .half_o (half_q),
      .cnt_o  (cnt_q)
   );

   beep_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SEL_LSB   (SEL_LSB),
      .SEL_W     (SEL_W),
      .CTRL_ADDR (CTRL_ADDR),
      .SEL_ADDR  (SEL_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .en_o      (en_q),
      .sel_o     (sel_q)
   );

   beep_tap_select #(
      .CNT_W      (CNT_W),
      .SEL_LSB    (SEL_LSB),
      .SEL_W      (SEL_W),
      .HALF_SHIFT (HALF_SHIFT),
      .SLOW_SHIFT (SLOW_SHIFT)
   ) u_tap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_i  (cnt_q),
      .sel_i  (sel_q),
      .en_i   (en_q),
      .freq_i (freq_i),
      .beep_o (beep_o)
   );

endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk #(
   parameter int CNT_W = 19,
   parameter int SEL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             half,
   input logic [CNT_W-1:0] cnt,
   input logic             en,
   input logic [SEL_W-1:0] sel,
   input logic             beep
);

   // R1: output low whenever reset is held
   p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !beep);

   // R2: count steps by one on the active prescale phase
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      half |=> cnt == CNT_W'($past(cnt) + 1'b1));

   // R2: count holds on the idle prescale phase
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !half |=> $stable(cnt));

   // R10: a write on an idle phase leaves the counter alone
   p_write_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !half) |=> $stable(cnt));

   // R8: empty or multi-bit select gives a low output one clock later
   p_bad_select_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sel) != 1) |=> !beep);

   // R9: a clear enable gives a low output one clock later
   p_disabled_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !beep);

endmodule

bind beep_tone_gen beep_tone_gen_chk #(
   .CNT_W (CNT_W),
   .SEL_W (SEL_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en_i),
   .half  (half_q),
   .cnt   (cnt_q),
   .en    (en_q),
   .sel   (sel_q),
   .beep  (beep_o)
);

// File: tb/sim_beep_tone_gen.sv
`timescale 1ns/1ps
module sim_beep_tone_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic [1:0]  freq = 2'd0;
   logic        beep;

   always #2.5 clk = ~clk;

   beep_tone_gen u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .freq_i    (freq),
      .beep_o    (beep)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural model: edges since reset, shadow registers, expected output
   int unsigned m_n;
   bit          m_en;
   bit [8:0]    m_sel;
   bit          m_exp;

   function automatic bit model_out(bit en, bit [8:0] sel, int unsigned n, bit [1:0] fr);
      int ones = 0;
      int pos = 0;
      int idx;
      int sh;
      for (int i = 0; i < 9; i++) begin
         if (sel[i]) begin
            ones++;
            pos = i;
         end
      end
      if (!en || ones != 1) return 1'b0;
      sh = (fr == 2'b01) ? 1 : (fr == 2'b10) ? 5 : 0;
      idx = 10 + pos - sh;
      if (idx < 0) idx = 0;
      return bit'(((n / 2) >> idx) & 1);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_n   <= 0;
         m_en  <= 1'b0;
         m_sel <= 9'd0;
         m_exp <= 1'b0;
      end else begin
         m_exp <= model_out(m_en, m_sel, m_n, freq);
         m_n   <= m_n + 1;
         if (wr_en && wr_addr == 2'd0) m_en  <= wr_data[0];
         if (wr_en && wr_addr == 2'd1) m_sel <= wr_data[18:10];
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // every clock, away from the active edge, compare against the model
   always @(negedge clk) begin
      if (rst_n && !done) check(beep == m_exp, cur_req, int'(beep), int'(m_exp));
   end

   task automatic wr(bit [1:0] a, bit [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = 32'd0;
   endtask

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int rise1, rise2;
      // R1: reset state
      run(4);
      check(beep == 1'b0, "R1", int'(beep), 0);
      rst_n = 1'b1;
      run(1);
      check(beep == 1'b0, "R1", int'(beep), 0);

      // R2: bit 10 at full speed, period 4096
      cur_req = "R2";
      wr(2'd1, 32'h0000_0400);
      wr(2'd0, 32'h0000_0001);
      rise1 = -1;
      rise2 = -1;
      for (int c = 0; c < 9000 && rise2 < 0; c++) begin
         logic prev;
         prev = beep;
         @(negedge clk);
         if (!prev && beep) begin
            if (rise1 < 0) rise1 = c;
            else rise2 = c;
         end
      end
      check(rise2 - rise1 == 4096, "R2", rise2 - rise1, 4096);

      // R3: reserved bits around the field are ignored (field bit 1 = data bit 11)
      cur_req = "R3";
      wr(2'd1, 32'hFFF8_0BFF);
      run(5000);

      // R4: only bit 0 of control matters; addresses 2 and 3 change nothing
      cur_req = "R4";
      wr(2'd0, 32'hFFFF_FFFE);
      run(3);
      check(beep == 1'b0, "R4", int'(beep), 0);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      run(3000);
      wr(2'd0, 32'hFFFF_FFFF);
      run(3000);

      // R5: half speed
      cur_req = "R5";
      freq = 2'b01;
      run(4000);

      // R6: one thirty-second speed
      cur_req = "R6";
      freq = 2'b10;
      wr(2'd1, 32'h0000_0400);
      run(2000);

      // R7: codes 00 and 11 both unshifted
      cur_req = "R7";
      freq = 2'b11;
      run(3000);
      freq = 2'b00;
      run(3000);

      // R8: empty and multi-bit selects
      cur_req = "R8";
      wr(2'd1, 32'h0000_0000);
      run(2500);
      check(beep == 1'b0, "R8", int'(beep), 0);
      wr(2'd1, 32'h0000_0C00);
      run(2500);
      check(beep == 1'b0, "R8", int'(beep), 0);

      // R9: disable while the output is high
      cur_req = "R9";
      wr(2'd1, 32'h0000_0400);
      for (int c = 0; c < 5000 && !beep; c++) @(negedge clk);
      check(beep == 1'b1, "R9", int'(beep), 1);
      wr(2'd0, 32'h0000_0000);
      run(1);
      check(beep == 1'b0, "R9", int'(beep), 0);
      run(3000);

      // R10: frequent writes leave the counter phase intact
      cur_req = "R10";
      wr(2'd0, 32'h0000_0001);
      for (int k = 0; k < 80; k++) begin
         wr(2'd1, 32'h0000_0400);
         run(47);
      end
      freq = 2'b10;
      run(500);

      finish_run();
   end

endmodule